// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers a set of interrupt request lines and latches each one as a pending request. Every source has a programmable urgency level. A smaller level number is more urgent, and level 0 is the most urgent. The block works out which pending source the CPU should take next. It offers that source's index on a valid/acknowledge handshake.

The block keeps a stack of the levels whose handlers are running. A new request interrupts a running handler only when its level is strictly more urgent than the level on top of that stack. A request that is equal or less urgent waits until an end-of-service pulse pops the stack. A global enable flag gates every offer. Software sets it with an enable command and clears it with a disable command. The block also clears it by itself whenever a request is accepted, so a handler stays uninterrupted until it re-enables interrupts.

Two pending requests with the same level are always resolved by a fixed rank. The lower source index wins, whatever order the requests arrived in.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset no source is pending, the global enable is clear, the in-service stack is empty, every level register holds 7, and `take_valid` is 0.
- R2: A pending bit is set on the clock edge where its request line is sampled 1 after being sampled 0. Holding the line high adds nothing. Lowering and raising the line again while the bit is still set merges into the one existing request, which is accepted only once.
- R3: `take_valid` is 1 only while the global enable is set. `irq_cmd` = 1 sets the enable and `irq_cmd` = 2 clears it; the values 0 and 3 leave it unchanged. The change is visible on the cycle after the command.
- R4: An acceptance (`take_valid` and `take_ack` high at one edge) does three things: it clears the pending bit of `take_idx`, pushes that source's level onto the in-service stack, and clears the global enable. Clearing the enable takes priority over an enable command given in the same cycle. `take_ack` is ignored while `take_valid` is 0.
- R5: The offered source has the smallest level value among pending sources. Among pending sources with that level, the lowest index is offered.
- R6: While the in-service stack is not empty, a source is offered only if its level is numerically smaller than the level on top of the stack. An equal level does not preempt.
- R7: An `eos` pulse pops the in-service stack. An `eos` pulse while the stack is empty is ignored. While the stack is empty, any pending source can be offered when the enable is set.
- R8: A level write (`lvl_wr_en`) stores `lvl_wr_data` for source `lvl_wr_idx`. The new level takes part in selection from the next cycle on.
- R9: If a rising edge of a source's request line arrives in the same cycle as that source's acceptance, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NSRC | Level-sensitive request lines, one per source |
| lvl_wr_en | input | 1 | Write strobe for a level register |
| lvl_wr_idx | input | log2(NSRC) | Source whose level is written |
| lvl_wr_data | input | 3 | New level, 0 most urgent |
| irq_cmd | input | 2 | 0 none, 1 set enable, 2 clear enable, 3 none |
| take_valid | output | 1 | A source is offered to the CPU |
| take_idx | output | log2(NSRC) | Index of the offered source |
| take_ack | input | 1 | CPU accepts the offered source |
| eos | input | 1 | End-of-service pulse for the innermost handler |

## Verification
Directed sequences raise several sources at once, with mixed levels and with tied levels. These separate selection by level from selection by index, and show that arrival order has no effect. Other sequences hold the stack at an equal level or at a more urgent level, which separates strict preemption from equal-level blocking. Further cases pop the stack, issue an end-of-service pulse on an empty stack, re-pulse a request line that is already pending, and raise a new edge in the same cycle as that source's acceptance. A long run of random request toggles, commands, acknowledges, end-of-service pulses and level writes is then checked every cycle against a bench model of the pending bits, enable flag and stack.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NIC_SOURCES = 16;
    localparam int NIC_LEVELS  = 8;
    localparam int NIC_DEPTH   = 8;
    localparam int NIC_LVL_W   = $clog2(NIC_LEVELS);

    typedef logic [NIC_LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_LEAST = lvl_t'(NIC_LEVELS - 1);

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_EI  = 2'd1,
        CMD_DI  = 2'd2,
        CMD_RSV = 2'd3
    } cmd_e;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } lvl_sel_t;

    // true when level a is strictly more urgent than level b
    function automatic logic outranks(lvl_t a, lvl_t b);
        return a < b;
    endfunction
endpackage

// File: rtl/nic_pend.sv
module nic_pend #(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  pend
);
    logic [NSRC-1:0] prev_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_cell
        logic rise;
        logic clr;
        assign rise = req[g] & ~prev_q[g];
        assign clr  = clr_en && (clr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
                pend[g]   <= 1'b0;
            end else begin
                prev_q[g] <= req[g];
                // a fresh edge wins over the clear of an acceptance
                pend[g]   <= (pend[g] & ~clr) | rise;
            end
        end
    end
endmodule

// File: rtl/nic_arb.sv
module nic_arb
    import nic_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4
) (
    input  logic [NSRC-1:0]                pend,
    input  logic [NSRC-1:0][NIC_LVL_W-1:0] lvl,
    output lvl_sel_t                       best,
    output logic [IDX_W-1:0]               best_idx
);
    always_comb begin
        best     = '0;
        best_idx = '0;
        // scan from the top index down so a tie leaves the lowest index
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (!best.hit || !outranks(best.lvl, lvl[i]))) begin
                best.hit = 1'b1;
                best.lvl = lvl[i];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nic_stack.sv
module nic_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  lvl_t          push_lvl,
    input  logic          pop,
    output lvl_t          top_lvl,
    output logic          empty,
    output logic          full,
    output logic [DW-1:0] depth
);
    lvl_t          mem [DEPTH];
    logic          do_pop;
    logic [DW-1:0] wr_ptr;
    logic [DW-1:0] rd_ptr;

    assign empty  = (depth == '0);
    assign full   = (depth == DW'(DEPTH));
    assign do_pop = pop && !empty;
    assign wr_ptr = depth - DW'(do_pop);
    assign rd_ptr = depth - DW'(1);
    assign top_lvl = empty ? LVL_LEAST : mem[rd_ptr[SW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else begin
            if (push && (wr_ptr < DW'(DEPTH))) begin
                mem[wr_ptr[SW-1:0]] <= push_lvl;
            end
            depth <= depth - DW'(do_pop) + DW'(push);
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NSRC   = NIC_SOURCES,
    parameter int DEPTH  = NIC_DEPTH,
    localparam int IDX_W = $clog2(NSRC),
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  irq_req,
    input  logic             lvl_wr_en,
    input  logic [IDX_W-1:0] lvl_wr_idx,
    input  logic [NIC_LVL_W-1:0] lvl_wr_data,
    input  logic [1:0]       irq_cmd,
    output logic             take_valid,
    output logic [IDX_W-1:0] take_idx,
    input  logic             take_ack,
    input  logic             eos
);
    logic [NSRC-1:0]                pend_q;
    logic [NSRC-1:0][NIC_LVL_W-1:0] lvl_q;
    lvl_sel_t                       cand;
    logic [IDX_W-1:0]               cand_idx;
    lvl_t                           top_lvl;
    logic                           stk_empty;
    logic                           stk_full;
    logic [DW-1:0]                  stk_depth;
    logic                           gie_q;
    logic                           accept;
    cmd_e                           cmd;

    assign cmd = cmd_e'(irq_cmd);

    for (genvar g = 0; g < NSRC; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[g] <= LVL_LEAST;
            end else if (lvl_wr_en && (lvl_wr_idx == IDX_W'(g))) begin
                lvl_q[g] <= lvl_wr_data;
            end
        end
    end

    nic_pend #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .clr_en  (accept),
        .clr_idx (cand_idx),
        .pend    (pend_q)
    );

    nic_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .pend     (pend_q),
        .lvl      (lvl_q),
        .best     (cand),
        .best_idx (cand_idx)
    );

    nic_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_lvl (cand.lvl),
        .pop      (eos),
        .top_lvl  (top_lvl),
        .empty    (stk_empty),
        .full     (stk_full),
        .depth    (stk_depth)
    );

    assign take_valid = gie_q && cand.hit && !stk_full &&
                        (stk_empty || outranks(cand.lvl, top_lvl));
    assign take_idx   = cand_idx;
    assign accept     = take_valid && take_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else if (accept) begin
            gie_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_EI:  gie_q <= 1'b1;
                CMD_DI:  gie_q <= 1'b0;
                default: gie_q <= gie_q;
            endcase
        end
    end
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int NSRC   = 16,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 3,
    localparam int IDX_W = $clog2(NSRC),
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       take_valid,
    input logic [IDX_W-1:0]           take_idx,
    input logic                       take_ack,
    input logic                       eos,
    input logic [NSRC-1:0]            pend,
    input logic [NSRC-1:0][LVL_W-1:0] lvl,
    input logic [LVL_W-1:0]           top_lvl,
    input logic                       empty,
    input logic [DW-1:0]              depth
);
    logic acc;
    assign acc = take_valid && take_ack;

    // R4
    accept_gie_clr_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> !take_valid);

    // R2
    offer_pending_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> pend[take_idx]);

    // R6
    preempt_strict_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && !empty) |-> (lvl[take_idx] < top_lvl));

    // R4
    push_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !eos) |=> (depth == $past(depth) + 1));

    // R7
    pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (eos && !empty && !acc) |=> (depth + 1 == $past(depth)));

    // R7
    idle_eos_chk: assert property (@(posedge clk) disable iff (rst)
        (eos && empty && !acc) |=> empty);

    for (genvar j = 0; j < NSRC; j++) begin : g_ord
        // R5
        arb_order_chk: assert property (@(posedge clk) disable iff (rst)
            (take_valid && pend[j]) |->
                ((lvl[j] > lvl[take_idx]) ||
                 ((lvl[j] == lvl[take_idx]) && (IDX_W'(j) >= take_idx))));
    end
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .NSRC  (NSRC),
    .DEPTH (DEPTH),
    .LVL_W (nic_pkg::NIC_LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .take_valid (take_valid),
    .take_idx   (take_idx),
    .take_ack   (take_ack),
    .eos        (eos),
    .pend       (pend_q),
    .lvl        (lvl_q),
    .top_lvl    (top_lvl),
    .empty      (stk_empty),
    .depth      (stk_depth)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int NS = 16;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_r = '0;
    logic        wen_r = 1'b0;
    logic [3:0]  widx_r = '0;
    logic [2:0]  wdat_r = '0;
    logic [1:0]  cmd_r = 2'd0;
    logic        ack_r = 1'b0;
    logic        eos_r = 1'b0;
    logic        take_valid;
    logic [3:0]  take_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model
    logic [15:0] m_pend, m_prev;
    logic [2:0]  m_lvl [NS];
    logic [2:0]  m_stk [ND];
    int          m_depth;
    logic        m_gie;
    logic        e_valid;
    logic [3:0]  e_idx;

    always #2 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_r),
        .lvl_wr_en  (wen_r),
        .lvl_wr_idx (widx_r),
        .lvl_wr_data(wdat_r),
        .irq_cmd    (cmd_r),
        .take_valid (take_valid),
        .take_idx   (take_idx),
        .take_ack   (ack_r),
        .eos        (eos_r)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_calc();
        bit       found = 0;
        logic [2:0] bl = 3'd0;
        e_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (m_pend[i] && (!found || m_lvl[i] <= bl)) begin
                found = 1;
                bl    = m_lvl[i];
                e_idx = 4'(i);
            end
        end
        e_valid = m_gie && found && (m_depth < ND) &&
                  ((m_depth == 0) || (bl < m_stk[m_depth-1]));
    endtask

    task automatic model_reset();
        m_pend = '0; m_prev = '0; m_gie = 0; m_depth = 0;
        for (int i = 0; i < NS; i++) m_lvl[i] = 3'd7;
        model_calc();
    endtask

    task automatic model_edge();
        bit          acc;
        bit          pop;
        logic [15:0] clr;
        acc = e_valid && ack_r;
        pop = eos_r && (m_depth > 0);
        clr = '0;
        if (acc) begin
            clr[e_idx] = 1'b1;
            m_stk[m_depth - int'(pop)] = m_lvl[e_idx];
        end
        m_pend  = (m_pend & ~clr) | (irq_r & ~m_prev);
        m_prev  = irq_r;
        m_depth = m_depth - int'(pop) + int'(acc);
        if (acc) m_gie = 0;
        else if (cmd_r == 2'd1) m_gie = 1;
        else if (cmd_r == 2'd2) m_gie = 0;
        if (wen_r) m_lvl[widx_r] = wdat_r;
        model_calc();
    endtask

    // one clock: apply held inputs, compare at the following negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R6 offer valid vs model", 32'(take_valid), 32'(e_valid));
        if (e_valid) check("R5 offer index vs model", 32'(take_idx), 32'(e_idx));
        cmd_r = 2'd0; ack_r = 0; eos_r = 0; wen_r = 0;
    endtask

    task automatic wr_lvl(int idx, int val);
        wen_r = 1; widx_r = 4'(idx); wdat_r = 3'(val);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset take_valid", 32'(take_valid), 0);

        // R3: pending but enable clear
        irq_r[4] = 1; step();
        check("R3 no offer while disabled", 32'(take_valid), 0);
        cmd_r = 2'd1; step();
        check("R3 offer after enable", 32'(take_valid), 1);
        check("R3 offered index", 32'(take_idx), 4);

        // R5/R8: levels written together with new edges
        wr_lvl(2, 5); irq_r[2] = 1; irq_r[9] = 1; irq_r[11] = 1; step();
        wr_lvl(9, 1); step();
        wr_lvl(11, 1); step();
        check("R5 tie lowest index", 32'(take_idx), 9);

        ack_r = 1; cmd_r = 2'd1; step();
        check("R4 enable cleared by accept", 32'(take_valid), 0);
        cmd_r = 2'd1; step();
        check("R6 equal level blocked", 32'(take_valid), 0);
        wr_lvl(2, 0); step();
        check("R8 new level preempts", 32'(take_valid), 1);
        check("R6 preempting index", 32'(take_idx), 2);
        ack_r = 1; step();
        cmd_r = 2'd1; step();
        check("R6 less urgent blocked", 32'(take_valid), 0);
        eos_r = 1; step();
        check("R7 one pop still blocks", 32'(take_valid), 0);
        eos_r = 1; step();
        check("R7 empty stack offers", 32'(take_valid), 1);
        check("R7 offered index", 32'(take_idx), 11);

        // R2: merge of a re-pulse while pending
        irq_r[11] = 0; step();
        irq_r[11] = 1; step();
        ack_r = 1; step();
        eos_r = 1; cmd_r = 2'd1; step();
        check("R2 merged request not re-offered", 32'(take_idx), 4);
        ack_r = 1; step();
        eos_r = 1; step();

        // R9: new edge in the acceptance cycle
        irq_r[3] = 1; cmd_r = 2'd1; step();
        check("R9 source 3 offered", 32'(take_idx), 3);
        irq_r[3] = 0; step();
        irq_r[3] = 1; ack_r = 1; step();
        eos_r = 1; cmd_r = 2'd1; step();
        check("R9 source 3 still pending", 32'(take_valid), 1);
        check("R9 source 3 index", 32'(take_idx), 3);
        ack_r = 1; step();
        eos_r = 1; step();

        // R7: eos on empty stack ignored
        eos_r = 1; step();
        irq_r[6] = 1; irq_r[7] = 1; cmd_r = 2'd1; step();
        check("R7 offer 6", 32'(take_idx), 6);
        ack_r = 1; step();
        cmd_r = 2'd1; step();
        check("R7 no underflow, equal blocked", 32'(take_valid), 0);
        cmd_r = 2'd2; step();
        check("R3 disable", 32'(take_valid), 0);
        eos_r = 1; step();
        check("R3 still disabled after pop", 32'(take_valid), 0);

        // random phase
        for (int c = 0; c < 5000; c++) begin
            for (int b = 0; b < NS; b++)
                if ($urandom % 16 == 0) irq_r[b] = ~irq_r[b];
            case ($urandom % 12)
                0, 1: cmd_r = 2'd1;
                2:    cmd_r = 2'd2;
                3:    cmd_r = 2'd3;
                default: cmd_r = 2'd0;
            endcase
            ack_r = e_valid ? 1'($urandom % 2) : ($urandom % 8 == 0);
            eos_r = ($urandom % 5 == 0);
            if ($urandom % 10 == 0) wr_lvl(int'($urandom % 16), int'($urandom % 8));
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule